// File: doc/BRIEF.md
# Physical Register Scoreboard with Dependent Wakeup

This block keeps one ready bit per physical register and tracks which instruction-queue entries are waiting for which registers. The physical register count is the sum of the integer and floating-point register counts. When an entry is written, each of its source operands is resolved in one of three ways:

- the operand is not tracked at all, so it counts as ready;
- its register is already valid, so it is marked ready at once;
- otherwise the entry is recorded as a waiter on that register.

Waiters are held in a bit matrix with one row per register and one column per entry. Each destination of an inserted instruction makes its register not-ready again.

A completion names one destination tag. Every waiter in that register's row has the matching operand marked ready, the row is emptied, and the register's ready bit is set. A squash gives a sequence-number bound. Occupied entries younger than the bound are freed, and their matrix columns are cleared, so that no stale link survives. Each entry presents a ready output to the issue logic. Redefining a register that still has waiters is flagged on a dedicated error output.

Top module: `phys_reg_scoreboard`

## Requirements
- R1: After reset, every register ready bit and every entry ready output is 0.
- R2: An insert source whose valid bit is 0, or whose tag is at or above the physical register count, counts as ready and creates no waiter link.
- R3: An insert source whose register ready bit is already 1 is marked ready in the entry immediately. The entry_ready output rises on the cycle after the insert when all its sources are ready.
- R4: For each valid insert destination with a tag below the register count, that register's ready bit reads 0 on the cycle after the insert.
- R5: dst_busy_err is 1 in the cycle of an insert whose valid, tracked destination register still has waiters, unless a completion of that same register occurs in the same cycle.
- R6: A completion with a tag below the register count sets that register's ready bit on the next cycle. It marks ready, in every waiting entry, each source carrying that tag, and it empties that register's waiter row.
- R7: A completion whose tag is at or above the register count changes no register ready bit and wakes no entry.
- R8: entry_ready[e] is 1 only when entry e is occupied and all of its sources are marked ready.
- R9: A squash frees every occupied entry whose sequence number is strictly greater than the bound, compared as unsigned values with no wraparound. Freed entries show entry_ready 0 and lose all waiter links. Entries at or below the bound keep their state and links.
- R10: When a completion and an insert that reads the same register happen in one cycle, the new entry sees that source as ready and is not linked as a waiter.
- R11: When a completion and an insert destination name the same register in one cycle, the register reads not-ready afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert an instruction this cycle |
| ins_entry | input | EIDX_W (3) | Queue entry written by the insert |
| ins_seq | input | SEQ_W (8) | Sequence number of the inserted instruction |
| ins_src_tags | input | NUM_SRC*TAG_W (18) | Source tags, source s at bits [s*TAG_W +: TAG_W] |
| ins_src_vld | input | NUM_SRC (3) | Valid bit per source |
| ins_dst_tags | input | NUM_DST*TAG_W (12) | Destination tags, destination d at bits [d*TAG_W +: TAG_W] |
| ins_dst_vld | input | NUM_DST (2) | Valid bit per destination |
| cmp_valid | input | 1 | A producer completes this cycle |
| cmp_tag | input | TAG_W (6) | Destination tag of the completing producer |
| sq_valid | input | 1 | Squash this cycle |
| sq_bound | input | SEQ_W (8) | Entries with a larger sequence number are squashed |
| entry_ready | output | NUM_ENTRIES (8) | Per-entry all-sources-ready |
| reg_ready | output | NUM_REGS (32) | Per-register valid bit |
| dst_busy_err | output | 1 | Insert redefines a register that still has waiters |

## Verification
The hardest case to reach is a squashed entry's waiter link, because the link is never visible directly at the ports. The bench builds a mix of old and young entries that wait on two registers, and squashes with a bound that falls between them. It then inserts fresh instructions that redefine each register. The error output must stay low for the register whose only waiter was squashed, and must rise for the register whose waiter survived. A later completion must then wake only the survivor. Same-cycle forwarding and clear-versus-set priority are reached by driving an insert and a completion on the same clock edge.

// File: rtl/sb_pkg.sv
package sb_pkg;

    // Outcome of resolving one source operand at insert time.
    typedef struct packed {
        logic tracked;   // tag names a real physical register
        logic ready;     // operand needs no wakeup
        logic link;      // entry must be recorded as a waiter
    } src_dec_t;

    // Per-operand readiness kept inside a queue entry.
    typedef enum logic {
        OPND_WAIT  = 1'b0,
        OPND_READY = 1'b1
    } opnd_t;

    // Sequence ordering used by squash: larger means younger.
    function automatic logic seq_is_younger(input logic [31:0] seq,
                                            input logic [31:0] bound);
        return seq > bound;
    endfunction

endpackage

// File: rtl/sb_src_resolve.sv
module sb_src_resolve
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int TAG_W    = 6
) (
    input  logic [TAG_W-1:0]    tag,
    input  logic                vld,
    input  logic [NUM_REGS-1:0] sb_bits,
    input  logic                cmp_en,
    input  logic [TAG_W-1:0]    cmp_tag,
    output src_dec_t            dec,
    output logic [NUM_REGS-1:0] link_mask
);
    localparam int RIDX_W = $clog2(NUM_REGS);

    logic [RIDX_W-1:0] ridx;
    logic              trk;
    logic              hit;

    always_comb begin
        ridx = tag[RIDX_W-1:0];
        trk  = vld && (tag < TAG_W'(NUM_REGS));
        // A completion in the same cycle is forwarded to the reader.
        hit  = trk && (sb_bits[ridx] || (cmp_en && (cmp_tag == tag)));
        dec.tracked = trk;
        dec.ready   = !trk || hit;
        dec.link    = trk && !hit;
        link_mask   = '0;
        if (dec.link) begin
            link_mask[ridx] = 1'b1;
        end
    end

endmodule

// File: rtl/sb_wait_matrix.sv
module sb_wait_matrix #(
    parameter int NUM_REGS    = 32,
    parameter int NUM_ENTRIES = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            set_en,
    input  logic [NUM_ENTRIES-1:0]          set_col,
    input  logic [NUM_REGS-1:0]             set_rows,
    input  logic                            clr_row_en,
    input  logic [$clog2(NUM_REGS)-1:0]     clr_row_idx,
    input  logic [NUM_ENTRIES-1:0]          clr_cols,
    input  logic [$clog2(NUM_REGS)-1:0]     rd_idx,
    output logic [NUM_REGS*NUM_ENTRIES-1:0] rows_flat,
    output logic [NUM_ENTRIES-1:0]          rd_col,
    output logic [NUM_REGS-1:0]             row_busy
);
    localparam int RIDX_W = $clog2(NUM_REGS);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
        logic [NUM_ENTRIES-1:0] row_q;
        logic                   row_wipe;

        assign row_wipe = clr_row_en && (clr_row_idx == RIDX_W'(r));

        always_ff @(posedge clk) begin
            if (rst) begin
                row_q <= '0;
            end else begin
                // Clears first, then the new links of an insert.
                row_q <= (row_q & ~clr_cols & {NUM_ENTRIES{~row_wipe}})
                       | ({NUM_ENTRIES{set_en && set_rows[r]}} & set_col);
            end
        end

        assign rows_flat[r*NUM_ENTRIES +: NUM_ENTRIES] = row_q;
        assign row_busy[r] = |row_q;
    end

    always_comb begin
        rd_col = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (rd_idx == RIDX_W'(r)) begin
                rd_col = rows_flat[r*NUM_ENTRIES +: NUM_ENTRIES];
            end
        end
    end

endmodule

// File: rtl/sb_entry_slot.sv
module sb_entry_slot
    import sb_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int TAG_W   = 6,
    parameter int SEQ_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ins_sel,
    input  logic [SEQ_W-1:0]         ins_seq,
    input  logic [NUM_SRC*TAG_W-1:0] ins_tags,
    input  logic [NUM_SRC-1:0]       ins_ready,
    input  logic                     cmp_en,
    input  logic [TAG_W-1:0]         cmp_tag,
    input  logic                     cmp_link,
    input  logic                     sq_valid,
    input  logic [SEQ_W-1:0]         sq_bound,
    output logic                     ready,
    output logic                     sq_hit
);
    logic                   valid_q;
    logic [SEQ_W-1:0]       seq_q;
    logic [TAG_W-1:0]       tag_q [NUM_SRC];
    opnd_t                  st_q  [NUM_SRC];
    logic [NUM_SRC-1:0]     all_rdy;

    assign sq_hit = sq_valid && valid_q
                 && seq_is_younger(32'(seq_q), 32'(sq_bound));

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            seq_q   <= '0;
            for (int s = 0; s < NUM_SRC; s++) begin
                tag_q[s] <= '0;
                st_q[s]  <= OPND_WAIT;
            end
        end else if (ins_sel) begin
            valid_q <= 1'b1;
            seq_q   <= ins_seq;
            for (int s = 0; s < NUM_SRC; s++) begin
                tag_q[s] <= ins_tags[s*TAG_W +: TAG_W];
                st_q[s]  <= ins_ready[s] ? OPND_READY : OPND_WAIT;
            end
        end else if (sq_hit) begin
            valid_q <= 1'b0;
        end else begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (valid_q && (st_q[s] == OPND_WAIT) && cmp_en
                    && cmp_link && (tag_q[s] == cmp_tag)) begin
                    st_q[s] <= OPND_READY;
                end
            end
        end
    end

    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            all_rdy[s] = (st_q[s] == OPND_READY);
        end
    end

    assign ready = valid_q && (&all_rdy);

endmodule

// File: rtl/phys_reg_scoreboard.sv
module phys_reg_scoreboard
    import sb_pkg::*;
#(
    parameter  int INT_REGS    = 16,
    parameter  int FP_REGS     = 16,
    parameter  int NUM_ENTRIES = 8,
    parameter  int NUM_SRC     = 3,
    parameter  int NUM_DST     = 2,
    parameter  int SEQ_W       = 8,
    localparam int NUM_REGS    = INT_REGS + FP_REGS,
    localparam int TAG_W       = $clog2(NUM_REGS) + 1,
    localparam int EIDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ins_valid,
    input  logic [EIDX_W-1:0]        ins_entry,
    input  logic [SEQ_W-1:0]         ins_seq,
    input  logic [NUM_SRC*TAG_W-1:0] ins_src_tags,
    input  logic [NUM_SRC-1:0]       ins_src_vld,
    input  logic [NUM_DST*TAG_W-1:0] ins_dst_tags,
    input  logic [NUM_DST-1:0]       ins_dst_vld,
    input  logic                     cmp_valid,
    input  logic [TAG_W-1:0]         cmp_tag,
    input  logic                     sq_valid,
    input  logic [SEQ_W-1:0]         sq_bound,
    output logic [NUM_ENTRIES-1:0]   entry_ready,
    output logic [NUM_REGS-1:0]      reg_ready,
    output logic                     dst_busy_err
);
    localparam int RIDX_W = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0]             sb_q;
    logic                            cmp_trk;
    logic [RIDX_W-1:0]               cmp_idx;
    src_dec_t                        src_dec   [NUM_SRC];
    logic [NUM_REGS-1:0]             link_masks[NUM_SRC];
    logic [NUM_REGS-1:0]             set_rows;
    logic [NUM_SRC-1:0]              src_rdy;
    logic [NUM_ENTRIES-1:0]          ins_onehot;
    logic [NUM_ENTRIES-1:0]          sq_hits;
    logic [NUM_ENTRIES-1:0]          clr_cols;
    logic [NUM_ENTRIES-1:0]          cmp_col;
    logic [NUM_REGS*NUM_ENTRIES-1:0] wait_rows;
    logic [NUM_REGS-1:0]             row_busy;
    logic [NUM_REGS-1:0]             dst_clr  [NUM_DST];
    logic [NUM_DST-1:0]              dst_err;
    logic [NUM_REGS-1:0]             clr_all;

    // Completion decode: untracked tags are dropped here.
    assign cmp_trk = cmp_valid && (cmp_tag < TAG_W'(NUM_REGS));
    assign cmp_idx = cmp_tag[RIDX_W-1:0];

    // Source resolution, one resolver per operand slot.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        sb_src_resolve #(
            .NUM_REGS (NUM_REGS),
            .TAG_W    (TAG_W)
        ) u_res (
            .tag       (ins_src_tags[s*TAG_W +: TAG_W]),
            .vld       (ins_src_vld[s]),
            .sb_bits   (sb_q),
            .cmp_en    (cmp_trk),
            .cmp_tag   (cmp_tag),
            .dec       (src_dec[s]),
            .link_mask (link_masks[s])
        );
        assign src_rdy[s] = src_dec[s].ready;
    end

    always_comb begin
        set_rows = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            set_rows = set_rows | link_masks[s];
        end
    end

    // Destination decode: clear masks and the redefinition check.
    for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
        logic [TAG_W-1:0]  dtag;
        logic [RIDX_W-1:0] didx;
        logic              dtrk;

        assign dtag = ins_dst_tags[d*TAG_W +: TAG_W];
        assign didx = dtag[RIDX_W-1:0];
        assign dtrk = ins_valid && ins_dst_vld[d] && (dtag < TAG_W'(NUM_REGS));

        always_comb begin
            dst_clr[d] = '0;
            if (dtrk) begin
                dst_clr[d][didx] = 1'b1;
            end
        end

        assign dst_err[d] = dtrk && row_busy[didx]
                         && !(cmp_trk && (cmp_idx == didx));
    end

    always_comb begin
        clr_all = '0;
        for (int d = 0; d < NUM_DST; d++) begin
            clr_all = clr_all | dst_clr[d];
        end
    end

    assign dst_busy_err = |dst_err;

    // Register ready bits: a redefinition overrides a same-cycle completion.
    always_ff @(posedge clk) begin
        if (rst) begin
            sb_q <= '0;
        end else begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (clr_all[r]) begin
                    sb_q[r] <= 1'b0;
                end else if (cmp_trk && (cmp_idx == RIDX_W'(r))) begin
                    sb_q[r] <= 1'b1;
                end
            end
        end
    end

    assign reg_ready = sb_q;

    always_comb begin
        ins_onehot = '0;
        if (ins_valid) begin
            ins_onehot[ins_entry] = 1'b1;
        end
    end

    assign clr_cols = sq_hits | ins_onehot;

    sb_wait_matrix #(
        .NUM_REGS    (NUM_REGS),
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_mat (
        .clk         (clk),
        .rst         (rst),
        .set_en      (ins_valid),
        .set_col     (ins_onehot),
        .set_rows    (set_rows),
        .clr_row_en  (cmp_trk),
        .clr_row_idx (cmp_idx),
        .clr_cols    (clr_cols),
        .rd_idx      (cmp_idx),
        .rows_flat   (wait_rows),
        .rd_col      (cmp_col),
        .row_busy    (row_busy)
    );

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        sb_entry_slot #(
            .NUM_SRC (NUM_SRC),
            .TAG_W   (TAG_W),
            .SEQ_W   (SEQ_W)
        ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .ins_sel   (ins_valid && (ins_entry == EIDX_W'(e))),
            .ins_seq   (ins_seq),
            .ins_tags  (ins_src_tags),
            .ins_ready (src_rdy),
            .cmp_en    (cmp_trk),
            .cmp_tag   (cmp_tag),
            .cmp_link  (cmp_col[e]),
            .sq_valid  (sq_valid),
            .sq_bound  (sq_bound),
            .ready     (entry_ready[e]),
            .sq_hit    (sq_hits[e])
        );
    end

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int NUM_REGS    = 32,
    parameter int NUM_ENTRIES = 8,
    parameter int NUM_SRC     = 3,
    parameter int NUM_DST     = 2,
    parameter int TAG_W       = 6,
    parameter int EIDX_W      = 3
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            ins_valid,
    input logic [EIDX_W-1:0]               ins_entry,
    input logic [NUM_SRC*TAG_W-1:0]        ins_src_tags,
    input logic [NUM_SRC-1:0]              ins_src_vld,
    input logic [NUM_DST*TAG_W-1:0]        ins_dst_tags,
    input logic [NUM_DST-1:0]              ins_dst_vld,
    input logic                            cmp_valid,
    input logic [TAG_W-1:0]                cmp_tag,
    input logic                            sq_valid,
    input logic [NUM_ENTRIES-1:0]          entry_ready,
    input logic [NUM_REGS-1:0]             reg_ready,
    input logic [NUM_REGS*NUM_ENTRIES-1:0] wait_rows
);
    localparam int RIDX_W = $clog2(NUM_REGS);

    logic              cmp_trk;
    logic [RIDX_W-1:0] cmp_idx;
    logic              dst_on_cmp;
    logic [TAG_W-1:0]  s0_tag;
    int                s0_flat;

    assign cmp_trk = cmp_valid && (cmp_tag < TAG_W'(NUM_REGS));
    assign cmp_idx = cmp_tag[RIDX_W-1:0];
    assign s0_tag  = ins_src_tags[TAG_W-1:0];
    assign s0_flat = int'(s0_tag[RIDX_W-1:0]) * NUM_ENTRIES + int'(ins_entry);

    always_comb begin
        dst_on_cmp = 1'b0;
        for (int d = 0; d < NUM_DST; d++) begin
            if (ins_valid && ins_dst_vld[d]
                && (ins_dst_tags[d*TAG_W +: TAG_W] == cmp_tag)) begin
                dst_on_cmp = 1'b1;
            end
        end
    end

    // R6: completion of a tracked register makes it valid.
    assert_cmp_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (cmp_trk && !dst_on_cmp) |=> reg_ready[$past(cmp_idx)]);

    // R7: untracked completion leaves the register bits alone.
    assert_untracked_cmp_R7: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !cmp_trk && !ins_valid) |=> $stable(reg_ready));

    // R9: squash alone never raises an entry's readiness.
    assert_squash_no_rise_R9: assert property (@(posedge clk) disable iff (rst)
        (sq_valid && !ins_valid && !cmp_valid)
        |=> ($countones(entry_ready) <= $past($countones(entry_ready))));

    // R10: forwarded completion leaves no waiter link for the new entry.
    assert_forward_nolink_R10: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_src_vld[0] && (s0_tag < TAG_W'(NUM_REGS))
         && cmp_trk && (cmp_tag == s0_tag))
        |=> !wait_rows[$past(s0_flat)]);

    for (genvar d = 0; d < NUM_DST; d++) begin : g_dchk
        logic [TAG_W-1:0]  dtag;
        logic [RIDX_W-1:0] didx;
        assign dtag = ins_dst_tags[d*TAG_W +: TAG_W];
        assign didx = dtag[RIDX_W-1:0];

        // R4: a redefined register reads not-ready next cycle.
        assert_dst_clears_R4: assert property (@(posedge clk) disable iff (rst)
            (ins_valid && ins_dst_vld[d] && (dtag < TAG_W'(NUM_REGS)))
            |=> !reg_ready[$past(didx)]);
    end

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_echk
        logic col_busy;
        always_comb begin
            col_busy = 1'b0;
            for (int r = 0; r < NUM_REGS; r++) begin
                col_busy = col_busy | wait_rows[r*NUM_ENTRIES + e];
            end
        end

        // R8: a ready entry has no outstanding waiter link.
        assert_ready_nolinks_R8: assert property (@(posedge clk) disable iff (rst)
            entry_ready[e] |-> !col_busy);
    end

endmodule

bind phys_reg_scoreboard sb_checker #(
    .NUM_REGS    (NUM_REGS),
    .NUM_ENTRIES (NUM_ENTRIES),
    .NUM_SRC     (NUM_SRC),
    .NUM_DST     (NUM_DST),
    .TAG_W       (TAG_W),
    .EIDX_W      (EIDX_W)
) u_sb_checker (
    .clk          (clk),
    .rst          (rst),
    .ins_valid    (ins_valid),
    .ins_entry    (ins_entry),
    .ins_src_tags (ins_src_tags),
    .ins_src_vld  (ins_src_vld),
    .ins_dst_tags (ins_dst_tags),
    .ins_dst_vld  (ins_dst_vld),
    .cmp_valid    (cmp_valid),
    .cmp_tag      (cmp_tag),
    .sq_valid     (sq_valid),
    .entry_ready  (entry_ready),
    .reg_ready    (reg_ready),
    .wait_rows    (wait_rows)
);

// File: tb/test_phys_reg_scoreboard.sv
module test_phys_reg_scoreboard;

    localparam int NR = 32;
    localparam int NE = 8;
    localparam int TW = 6;

    logic           clk = 1'b0;
    logic           rst;
    logic           ins_valid;
    logic [2:0]     ins_entry;
    logic [7:0]     ins_seq;
    logic [17:0]    ins_src_tags;
    logic [2:0]     ins_src_vld;
    logic [11:0]    ins_dst_tags;
    logic [1:0]     ins_dst_vld;
    logic           cmp_valid;
    logic [5:0]     cmp_tag;
    logic           sq_valid;
    logic [7:0]     sq_bound;
    logic [NE-1:0]  entry_ready;
    logic [NR-1:0]  reg_ready;
    logic           dst_busy_err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    phys_reg_scoreboard i_phys_reg_scoreboard (
        .clk          (clk),
        .rst          (rst),
        .ins_valid    (ins_valid),
        .ins_entry    (ins_entry),
        .ins_seq      (ins_seq),
        .ins_src_tags (ins_src_tags),
        .ins_src_vld  (ins_src_vld),
        .ins_dst_tags (ins_dst_tags),
        .ins_dst_vld  (ins_dst_vld),
        .cmp_valid    (cmp_valid),
        .cmp_tag      (cmp_tag),
        .sq_valid     (sq_valid),
        .sq_bound     (sq_bound),
        .entry_ready  (entry_ready),
        .reg_ready    (reg_ready),
        .dst_busy_err (dst_busy_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        ins_valid = 0; ins_entry = 0; ins_seq = 0;
        ins_src_tags = 0; ins_src_vld = 0;
        ins_dst_tags = 0; ins_dst_vld = 0;
        cmp_valid = 0; cmp_tag = 0; sq_valid = 0; sq_bound = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    // Drives an insert; sources a,b,c with valid mask sv; dests x,y with mask dv.
    task automatic set_ins(input int e, input int seq,
                           input int a, input int b, input int c, input logic [2:0] sv,
                           input int x, input int y, input logic [1:0] dv);
        ins_valid = 1; ins_entry = 3'(e); ins_seq = 8'(seq);
        ins_src_tags = {6'(c), 6'(b), 6'(a)}; ins_src_vld = sv;
        ins_dst_tags = {6'(y), 6'(x)}; ins_dst_vld = dv;
    endtask

    task automatic complete(input int t);
        cmp_valid = 1; cmp_tag = 6'(t);
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reg_ready after reset", 64'(reg_ready), 64'h0);
        check("R1 entry_ready after reset", 64'(entry_ready), 64'h0);
    endtask

    task automatic t_untracked_src();
        do_reset();
        // source 40 and 63 are beyond the register file; source 5 is not valid
        set_ins(0, 1, 40, 5, 63, 3'b101, 0, 0, 2'b00);
        tick();
        check("R2 untracked/invalid sources ready", 64'(entry_ready[0]), 64'h1);
        check("R8 only occupied entries ready", 64'(entry_ready), 64'h1);
    endtask

    task automatic t_sb_hit();
        do_reset();
        complete(3);
        check("R6 completion sets reg 3", 64'(reg_ready[3]), 64'h1);
        set_ins(1, 2, 3, 3, 0, 3'b011, 0, 0, 2'b00);
        tick();
        check("R3 valid source ready at insert", 64'(entry_ready[1]), 64'h1);
    endtask

    task automatic t_wait_wake();
        do_reset();
        set_ins(2, 4, 7, 8, 7, 3'b111, 0, 0, 2'b00);
        tick();
        check("R8 waiting entry not ready", 64'(entry_ready[2]), 64'h0);
        complete(7);
        check("R8 one source still waiting", 64'(entry_ready[2]), 64'h0);
        complete(8);
        check("R6 all waiters woken", 64'(entry_ready[2]), 64'h1);
        check("R6 reg bits 7 and 8", 64'(reg_ready), 64'h180);
    endtask

    task automatic t_dst_clear();
        do_reset();
        complete(3);
        set_ins(4, 5, 0, 0, 0, 3'b000, 3, 45, 2'b11);
        tick();
        check("R4 destination cleared", 64'(reg_ready[3]), 64'h0);
        set_ins(5, 6, 3, 0, 0, 3'b001, 0, 0, 2'b00);
        tick();
        check("R4 reader of cleared reg waits", 64'(entry_ready[5]), 64'h0);
    endtask

    task automatic t_redef_err();
        do_reset();
        set_ins(6, 7, 9, 0, 0, 3'b001, 0, 0, 2'b00);
        tick();
        set_ins(7, 8, 0, 0, 0, 3'b000, 20, 9, 2'b11);
        #1;
        check("R5 redefinition with waiters flagged", 64'(dst_busy_err), 64'h1);
        tick();
        set_ins(3, 9, 0, 0, 0, 3'b000, 9, 0, 2'b01);
        cmp_valid = 1; cmp_tag = 6'd9;
        #1;
        check("R5 same-cycle completion suppresses flag", 64'(dst_busy_err), 64'h0);
        tick();
        check("R6 waiter woken by completion", 64'(entry_ready[6]), 64'h1);
    endtask

    task automatic t_untracked_cmp();
        do_reset();
        complete(1);
        set_ins(0, 1, 33, 0, 0, 3'b001, 0, 0, 2'b00);
        tick();
        complete(33);
        check("R7 untracked completion no reg change", 64'(reg_ready), 64'h2);
        check("R7 untracked completion wakes nothing", 64'(entry_ready), 64'h1);
    endtask

    task automatic t_forward();
        do_reset();
        set_ins(2, 3, 11, 0, 0, 3'b001, 0, 0, 2'b00);
        cmp_valid = 1; cmp_tag = 6'd11;
        tick();
        check("R10 same-cycle completion forwarded", 64'(entry_ready[2]), 64'h1);
        set_ins(5, 4, 0, 0, 0, 3'b000, 11, 0, 2'b01);
        #1;
        check("R10 no link left behind", 64'(dst_busy_err), 64'h0);
        tick();
    endtask

    task automatic t_clear_priority();
        do_reset();
        set_ins(1, 1, 0, 0, 0, 3'b000, 12, 0, 2'b01);
        cmp_valid = 1; cmp_tag = 6'd12;
        tick();
        check("R11 redefinition beats completion", 64'(reg_ready[12]), 64'h0);
    endtask

    task automatic t_squash();
        do_reset();
        set_ins(0, 10, 20, 0, 0, 3'b001, 0, 0, 2'b00);
        tick();
        set_ins(1, 30, 20, 0, 0, 3'b001, 0, 0, 2'b00);
        tick();
        set_ins(2, 40, 21, 0, 0, 3'b001, 0, 0, 2'b00);
        tick();
        set_ins(4, 20, 0, 0, 0, 3'b000, 0, 0, 2'b00);
        tick();
        check("R9 unsquashed entry ready before squash", 64'(entry_ready[4]), 64'h1);
        sq_valid = 1; sq_bound = 8'd20;
        tick();
        check("R9 entry at bound kept", 64'(entry_ready[4]), 64'h1);
        set_ins(5, 50, 0, 0, 0, 3'b000, 21, 0, 2'b01);
        #1;
        check("R9 squashed waiter link dropped", 64'(dst_busy_err), 64'h0);
        tick();
        set_ins(6, 51, 0, 0, 0, 3'b000, 20, 0, 2'b01);
        #1;
        check("R9 surviving waiter link kept", 64'(dst_busy_err), 64'h1);
        tick();
        complete(20);
        check("R9 survivor woken, squashed stays free", 64'(entry_ready), 64'h71);
    endtask

    initial begin
        rst = 1;
        idle();
        t_reset();
        t_untracked_src();
        t_sb_hit();
        t_wait_wake();
        t_dst_clear();
        t_redef_err();
        t_untracked_cmp();
        t_forward();
        t_clear_priority();
        t_squash();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule